// File: doc/BRIEF.md
# LPC Host Interrupt Status Unit

This block gathers every interrupt source of an LPC host controller into one 32-bit status word and decides, through a 32-bit enable mask of the same layout, whether to raise a summary request. It serves three groups of sources. The 17 serial-IRQ slot levels are sampled only while serial decoding is enabled, and they keep setting their status bit for as long as they are asserted. The bus-reset event and the six bus error events are single-cycle pulses that latch their bit until software clears it by writing 1. The two bus-master request pulses latch in the same way. When the first error of a burst arrives, the bus address that goes with it is captured.

The summary request feeds a second-level register set on the upstream side. It holds a status bit that software acknowledges by writing 1, a mask bit and a polarity bit, and together they drive the single interrupt pin toward the upstream bus master. Software reaches all registers through a simple single-cycle write port and a combinational read port.

Top module: `lpcirq_hub`

## Requirements
- R1: After synchronous reset every register reads 0, `summary_irq` is 0 and `up_irq` is 0.
- R2: While control bit 31 (serial enable) is 1, a high level on `serirq_lvl[n]` sets status bit 31-n (slot 0 is bit 31, slot 16 is bit 15, all-serial field 0xFFFF8000). While control bit 31 is 0 the serial levels set nothing.
- R3: A serial status bit is cleared by writing 1 to it at offset 0x38. The clear wins in the write cycle. The bit sets again on the next clock if its level is still high and stays 0 once the level is low.
- R4: Event bits latch on a one-cycle pulse and hold until a 1 is written to them at 0x38; writing 0 leaves them set. The bits are: bit 10 bus reset; bits 7..2 for `err_evt[0]`..`err_evt[5]` (abnormal sync, no-response sync, error sync, sync timeout, target turnaround, bus-master turnaround); bit 1 for `bm_req[0]`; bit 0 for `bm_req[1]`.
- R5: An event pulse in the same cycle as a write-1 clear of its bit leaves the bit set.
- R6: The mask register (0x34) has the status layout. `summary_irq` is the OR of status AND mask, so it rises one clock after a masked-in source latches.
- R7: The error address register (0x40) loads `err_addr` on an error pulse only while status bits 7..2 are all 0. Otherwise it holds its value.
- R8: Upstream status bit 11 (offset 0x50) sets on every clock that `summary_irq` is high, and a write of 1 to bit 11 clears it (the clear wins). Bit 11 of 0x54 is the upstream mask and bit 11 of 0x58 is the polarity. `up_irq` = (status AND mask) XOR polarity, so polarity 0 gives an active-high pin.
- R9: Offsets are 0x30 control, 0x34 mask, 0x38 status, 0x40 error address, 0x50/0x54/0x58 upstream. Unimplemented bits and unmapped offsets read 0. Mask bits exist only at 0xFFFF84FF. Writing the status offset never sets a bit. Writes to 0x40 are ignored.
- R10: The control register keeps bit 31 (serial enable), bit 30 (quiet mode) and bits 25:24 (start-frame width). Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | RADDR_W | Register byte offset for read and write |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| serirq_lvl | input | 17 | Decoded serial-IRQ slot levels, index = slot |
| bus_rst_evt | input | 1 | Bus reset event pulse |
| err_evt | input | 6 | Bus error event pulses |
| err_addr | input | EADDR_W | Bus address that goes with an error pulse |
| bm_req | input | 2 | Bus-master request pulses |
| summary_irq | output | 1 | OR of enabled status bits |
| up_irq | output | 1 | Upstream interrupt pin after mask and polarity |

## Verification
The bench goes after the collisions between software and hardware. An event pulse that meets a write-1 clear must survive; a design that lets the clear win loses an error. A serial level must come back after a clear; a design that treats the slots as edge events would leave the bit at 0. The error address must not move while an earlier error is pending and must move again once every error bit is clear; getting this wrong reports the address of a later, secondary fault. Random traffic then mixes mask, polarity and upstream acknowledgements against a cycle model, which exposes an off-by-one summary latency or a swapped slot order as a mismatch in the status word or on the pins.

// File: rtl/lpcirq_pkg.sv
package lpcirq_pkg;

    localparam int DW        = 32;
    localparam int NUM_SLOTS = 17;
    localparam int NUM_ERR   = 6;
    localparam int NUM_BM    = 2;

    // bit positions that software decodes
    localparam int SER_TOP   = 31;   // slot 0 lands here, later slots below
    localparam int BIT_BRST  = 10;
    localparam int ERR_TOP   = 7;    // err_evt[0] lands here, later ones below
    localparam int BM_TOP    = 1;    // bm_req[0] lands here
    localparam int UP_BIT    = 11;

    localparam logic [7:0] OFS_CTRL    = 8'h30;
    localparam logic [7:0] OFS_MASK    = 8'h34;
    localparam logic [7:0] OFS_STAT    = 8'h38;
    localparam logic [7:0] OFS_EADDR   = 8'h40;
    localparam logic [7:0] OFS_UP_STAT = 8'h50;
    localparam logic [7:0] OFS_UP_MASK = 8'h54;
    localparam logic [7:0] OFS_UP_POL  = 8'h58;

    typedef struct packed {
        logic       en;
        logic       quiet;
        logic [1:0] start_w;
    } ser_ctrl_t;

    typedef struct packed {
        logic [DW-1:0] lvl;   // level-driven part of the status word
        logic [DW-1:0] evt;   // edge-latched part of the status word
    } src_vec_t;

    function automatic logic [DW-1:0] ser_field();
        logic [DW-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SLOTS; s++) m[SER_TOP-s] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] evt_field();
        logic [DW-1:0] m;
        m = '0;
        m[BIT_BRST] = 1'b1;
        for (int e = 0; e < NUM_ERR; e++) m[ERR_TOP-e] = 1'b1;
        for (int b = 0; b < NUM_BM; b++)  m[BM_TOP-b]  = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] err_field();
        logic [DW-1:0] m;
        m = '0;
        for (int e = 0; e < NUM_ERR; e++) m[ERR_TOP-e] = 1'b1;
        return m;
    endfunction

    localparam logic [DW-1:0] SER_MASK  = ser_field();
    localparam logic [DW-1:0] EVT_MASK  = evt_field();
    localparam logic [DW-1:0] ERR_MASK  = err_field();
    localparam logic [DW-1:0] STAT_IMPL = SER_MASK | EVT_MASK;

    function automatic ser_ctrl_t ctrl_unpack(input logic [DW-1:0] w);
        ser_ctrl_t c;
        c.en      = w[31];
        c.quiet   = w[30];
        c.start_w = w[25:24];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctrl_pack(input ser_ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[31]    = c.en;
        w[30]    = c.quiet;
        w[25:24] = c.start_w;
        return w;
    endfunction

    function automatic logic [DW-1:0] up_place(input logic b);
        return DW'(b) << UP_BIT;
    endfunction

endpackage

// File: rtl/lpcirq_src_map.sv
module lpcirq_src_map
    import lpcirq_pkg::*;
(
    input  logic                 ser_en,
    input  logic [NUM_SLOTS-1:0] serirq_lvl,
    input  logic                 bus_rst_evt,
    input  logic [NUM_ERR-1:0]   err_evt,
    input  logic [NUM_BM-1:0]    bm_req,
    output src_vec_t             src
);

    always_comb begin
        src = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            src.lvl[SER_TOP-s] = serirq_lvl[s] & ser_en;
        src.evt[BIT_BRST] = bus_rst_evt;
        for (int e = 0; e < NUM_ERR; e++)
            src.evt[ERR_TOP-e] = err_evt[e];
        for (int b = 0; b < NUM_BM; b++)
            src.evt[BM_TOP-b] = bm_req[b];
    end

endmodule

// File: rtl/lpcirq_stat_bank.sv
module lpcirq_stat_bank
    import lpcirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  src_vec_t      src,
    input  logic          mask_we,
    input  logic [DW-1:0] mask_wdata,
    input  logic [DW-1:0] w1c,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] mask_q,
    output logic          summary
);

    logic [DW-1:0] lvl_next;
    logic [DW-1:0] evt_next;

    // level part: clear wins, source re-sets on the following clock
    assign lvl_next = (stat_q | src.lvl) & ~w1c & SER_MASK;
    // edge part: a new event wins over a clear in the same clock
    assign evt_next = ((stat_q & ~w1c) | src.evt) & EVT_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= lvl_next | evt_next;
            if (mask_we) mask_q <= mask_wdata & STAT_IMPL;
        end
    end

    assign summary = |(stat_q & mask_q);

endmodule

// File: rtl/lpcirq_err_cap.sv
module lpcirq_err_cap
    import lpcirq_pkg::*;
#(
    parameter int EADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DW-1:0]      stat_q,
    input  logic [NUM_ERR-1:0] err_evt,
    input  logic [EADDR_W-1:0] err_addr,
    output logic [EADDR_W-1:0] eaddr_q
);

    logic none_pending;
    logic capture;

    assign none_pending = (stat_q & ERR_MASK) == '0;
    assign capture      = (|err_evt) && none_pending;

    always_ff @(posedge clk) begin
        if (rst)          eaddr_q <= '0;
        else if (capture) eaddr_q <= err_addr;
    end

endmodule

// File: rtl/lpcirq_upstream.sv
module lpcirq_upstream (
    input  logic clk,
    input  logic rst,
    input  logic summary,
    input  logic ack,
    input  logic mask_we,
    input  logic pol_we,
    input  logic wbit,
    output logic up_stat_q,
    output logic up_mask_q,
    output logic up_pol_q,
    output logic up_irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_stat_q <= 1'b0;
            up_mask_q <= 1'b0;
            up_pol_q  <= 1'b0;
        end else begin
            if (ack)          up_stat_q <= 1'b0;
            else if (summary) up_stat_q <= 1'b1;
            if (mask_we) up_mask_q <= wbit;
            if (pol_we)  up_pol_q  <= wbit;
        end
    end

    assign up_irq = (up_stat_q & up_mask_q) ^ up_pol_q;

endmodule

// File: rtl/lpcirq_hub.sv
module lpcirq_hub
    import lpcirq_pkg::*;
#(
    parameter int EADDR_W = 32,
    parameter int RADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic                 reg_we,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [16:0]          serirq_lvl,
    input  logic                 bus_rst_evt,
    input  logic [5:0]           err_evt,
    input  logic [EADDR_W-1:0]   err_addr,
    input  logic [1:0]           bm_req,
    output logic                 summary_irq,
    output logic                 up_irq
);

    localparam logic [RADDR_W-1:0] A_CTRL  = RADDR_W'(OFS_CTRL);
    localparam logic [RADDR_W-1:0] A_MASK  = RADDR_W'(OFS_MASK);
    localparam logic [RADDR_W-1:0] A_STAT  = RADDR_W'(OFS_STAT);
    localparam logic [RADDR_W-1:0] A_EADDR = RADDR_W'(OFS_EADDR);
    localparam logic [RADDR_W-1:0] A_USTAT = RADDR_W'(OFS_UP_STAT);
    localparam logic [RADDR_W-1:0] A_UMASK = RADDR_W'(OFS_UP_MASK);
    localparam logic [RADDR_W-1:0] A_UPOL  = RADDR_W'(OFS_UP_POL);

    ser_ctrl_t            ser_ctrl;
    src_vec_t             src;
    logic [DW-1:0]        stat_q;
    logic [DW-1:0]        mask_q;
    logic [DW-1:0]        w1c;
    logic [EADDR_W-1:0]   eaddr_q;
    logic                 up_stat_q;
    logic                 up_mask_q;
    logic                 up_pol_q;
    logic                 wr_ctrl, wr_mask, wr_stat, wr_ustat, wr_umask, wr_upol;

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign wr_mask  = reg_we && (reg_addr == A_MASK);
    assign wr_stat  = reg_we && (reg_addr == A_STAT);
    assign wr_ustat = reg_we && (reg_addr == A_USTAT);
    assign wr_umask = reg_we && (reg_addr == A_UMASK);
    assign wr_upol  = reg_we && (reg_addr == A_UPOL);

    assign w1c = wr_stat ? (reg_wdata & STAT_IMPL) : '0;

    always_ff @(posedge clk) begin
        if (rst)          ser_ctrl <= '0;
        else if (wr_ctrl) ser_ctrl <= ctrl_unpack(reg_wdata);
    end

    lpcirq_src_map u_map (
        .ser_en      (ser_ctrl.en),
        .serirq_lvl  (serirq_lvl),
        .bus_rst_evt (bus_rst_evt),
        .err_evt     (err_evt),
        .bm_req      (bm_req),
        .src         (src)
    );

    lpcirq_stat_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .mask_we    (wr_mask),
        .mask_wdata (reg_wdata),
        .w1c        (w1c),
        .stat_q     (stat_q),
        .mask_q     (mask_q),
        .summary    (summary_irq)
    );

    lpcirq_err_cap #(.EADDR_W(EADDR_W)) u_ecap (
        .clk      (clk),
        .rst      (rst),
        .stat_q   (stat_q),
        .err_evt  (err_evt),
        .err_addr (err_addr),
        .eaddr_q  (eaddr_q)
    );

    lpcirq_upstream u_up (
        .clk       (clk),
        .rst       (rst),
        .summary   (summary_irq),
        .ack       (wr_ustat && reg_wdata[UP_BIT]),
        .mask_we   (wr_umask),
        .pol_we    (wr_upol),
        .wbit      (reg_wdata[UP_BIT]),
        .up_stat_q (up_stat_q),
        .up_mask_q (up_mask_q),
        .up_pol_q  (up_pol_q),
        .up_irq    (up_irq)
    );

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_pack(ser_ctrl);
            A_MASK:  reg_rdata = mask_q;
            A_STAT:  reg_rdata = stat_q;
            A_EADDR: reg_rdata = DW'(eaddr_q);
            A_USTAT: reg_rdata = up_place(up_stat_q);
            A_UMASK: reg_rdata = up_place(up_mask_q);
            A_UPOL:  reg_rdata = up_place(up_pol_q);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lpcirq_checker.sv
module lpcirq_checker
    import lpcirq_pkg::*;
#(
    parameter int EADDR_W = 32,
    parameter int RADDR_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic [RADDR_W-1:0] reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [5:0]         err_evt,
    input logic               summary_irq,
    input logic               ctrl_en,
    input logic [31:0]        stat_q,
    input logic [31:0]        mask_q,
    input logic [EADDR_W-1:0] eaddr_q,
    input logic               up_stat_q
);

    logic clr7, mask_wr, up_ack;
    assign clr7    = reg_we && (reg_addr == RADDR_W'(OFS_STAT)) && reg_wdata[7];
    assign mask_wr = reg_we && (reg_addr == RADDR_W'(OFS_MASK));
    assign up_ack  = reg_we && (reg_addr == RADDR_W'(OFS_UP_STAT)) && reg_wdata[UP_BIT];

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!summary_irq && stat_q == '0)); // R1
    AST_SER_GATED: assert property (@(posedge clk) disable iff (rst) (!ctrl_en && !stat_q[31]) |=> !stat_q[31]); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) (stat_q[7] && !clr7) |=> stat_q[7]); // R4
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst) err_evt[2] |=> stat_q[5]); // R5
    AST_SUMMARY_NEXT: assert property (@(posedge clk) disable iff (rst) (err_evt[0] && mask_q[7] && !mask_wr) |=> summary_irq); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (stat_q[7:2] != 6'd0) |=> $stable(eaddr_q)); // R7
    AST_UP_FOLLOW: assert property (@(posedge clk) disable iff (rst) (summary_irq && !up_ack) |=> up_stat_q); // R8

endmodule

bind lpcirq_hub lpcirq_checker #(.EADDR_W(EADDR_W), .RADDR_W(RADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .err_evt     (err_evt),
    .summary_irq (summary_irq),
    .ctrl_en     (ser_ctrl.en),
    .stat_q      (stat_q),
    .mask_q      (mask_q),
    .eaddr_q     (eaddr_q),
    .up_stat_q   (up_stat_q)
);

// File: tb/tb_lpcirq_hub.sv
module tb_lpcirq_hub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [16:0] serirq_lvl = '0;
    logic        bus_rst_evt = 1'b0;
    logic [5:0]  err_evt = '0;
    logic [31:0] err_addr = '0;
    logic [1:0]  bm_req = '0;
    logic        summary_irq;
    logic        up_irq;

    always #10 clk = ~clk;   // 50 MHz

    lpcirq_hub dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serirq_lvl(serirq_lvl),
        .bus_rst_evt(bus_rst_evt), .err_evt(err_evt), .err_addr(err_addr),
        .bm_req(bm_req), .summary_irq(summary_irq), .up_irq(up_irq)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // cycle model built from the requirements
    logic [31:0] m_ctrl = '0, m_mask = '0, m_stat = '0, m_eaddr = '0;
    logic [31:0] m_up = '0, m_upm = '0, m_pol = '0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    function automatic logic [31:0] slot_bit(input int s);
        return 32'h1 << (31 - s);
    endfunction

    task automatic model_step(input logic we, input logic [7:0] a, input logic [31:0] wd,
                              input logic rstev, input logic [5:0] err, input logic [1:0] bm,
                              input logic [31:0] ea);
        logic [31:0] ser, evt, w1c, nstat;
        logic sumc;
        ser = '0;
        for (int s = 0; s < 17; s++) if (m_ctrl[31] && serirq_lvl[s]) ser |= slot_bit(s);
        evt = '0;
        evt[10] = rstev;
        for (int i = 0; i < 6; i++) evt[7-i] = err[i];
        evt[1] = bm[0];
        evt[0] = bm[1];
        w1c  = (we && a == 8'h38) ? wd : '0;
        sumc = |(m_stat & m_mask);
        nstat = ((m_stat | ser) & ~w1c & 32'hFFFF_8000) | (((m_stat & ~w1c) | evt) & 32'h0000_04FF);
        if (|err && m_stat[7:2] == 6'd0) m_eaddr = ea;
        if (we && a == 8'h50 && wd[11]) m_up = '0;
        else if (sumc) m_up = 32'h800;
        if (we && a == 8'h30) m_ctrl = wd & 32'hC300_0000;
        if (we && a == 8'h34) m_mask = wd & 32'hFFFF_84FF;
        if (we && a == 8'h54) m_upm = wd & 32'h800;
        if (we && a == 8'h58) m_pol = wd & 32'h800;
        m_stat = nstat;
    endtask

    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] wd,
                       input logic rstev, input logic [5:0] err, input logic [1:0] bm,
                       input logic [31:0] ea);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        bus_rst_evt = rstev; err_evt = err; bm_req = bm; err_addr = ea;
        model_step(we, a, wd, rstev, err, bm, ea);
        @(posedge clk);
        #1;
        reg_we = 1'b0; bus_rst_evt = 1'b0; err_evt = '0; bm_req = '0;
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, '0, 1'b0, '0, '0, '0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        cyc(1'b1, a, wd, 1'b0, '0, '0, '0);
    endtask

    task automatic verify(input string tag);
        rd_chk({tag, " ctrl"}, 8'h30, m_ctrl);
        rd_chk({tag, " mask"}, 8'h34, m_mask);
        rd_chk({tag, " stat"}, 8'h38, m_stat);
        rd_chk({tag, " eaddr"}, 8'h40, m_eaddr);
        rd_chk({tag, " upstat"}, 8'h50, m_up);
        rd_chk({tag, " upmask"}, 8'h54, m_upm);
        rd_chk({tag, " uppol"}, 8'h58, m_pol);
        chk({tag, " summary_irq"}, 32'(summary_irq), 32'(|(m_stat & m_mask)));
        chk({tag, " up_irq"}, 32'(up_irq), 32'(((m_up & m_upm) ^ m_pol) != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        verify("R1");
        rd_chk("R1 stat after reset", 8'h38, 32'h0);

        // control and register map
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk("R10 ctrl fields", 8'h30, 32'hC300_0000);
        wr(8'h34, 32'hFFFF_FFFF);
        rd_chk("R9 mask implemented", 8'h34, 32'hFFFF_84FF);
        wr(8'h38, 32'hFFFF_FFFF);
        rd_chk("R9 stat write sets nothing", 8'h38, 32'h0);
        wr(8'h40, 32'hDEAD_BEEF);
        rd_chk("R9 eaddr write ignored", 8'h40, 32'h0);
        rd_chk("R9 unmapped 0x3C", 8'h3C, 32'h0);
        rd_chk("R9 unmapped 0x44", 8'h44, 32'h0);
        verify("R9");

        // slot mapping and enable
        serirq_lvl = 17'h00001; idle(); serirq_lvl = '0;
        rd_chk("R2 slot0 -> bit31", 8'h38, 32'h8000_0000);
        wr(8'h38, 32'h8000_0000);
        serirq_lvl = 17'h10000; idle(); serirq_lvl = '0;
        rd_chk("R2 slot16 -> bit15", 8'h38, 32'h0000_8000);
        wr(8'h38, 32'h0000_8000);
        wr(8'h30, 32'h0);
        serirq_lvl = '1; idle(); idle();
        rd_chk("R2 disabled slots ignored", 8'h38, 32'h0);
        serirq_lvl = '0;
        wr(8'h30, 32'h8000_0000);
        verify("R2");

        // level semantics
        serirq_lvl = 17'h00008; idle();
        rd_chk("R3 slot3 set", 8'h38, 32'h1000_0000);
        wr(8'h38, 32'h1000_0000);
        rd_chk("R3 clear wins in write cycle", 8'h38, 32'h0);
        idle();
        rd_chk("R3 level re-sets", 8'h38, 32'h1000_0000);
        serirq_lvl = '0;
        wr(8'h38, 32'h1000_0000); idle();
        rd_chk("R3 stays clear after level drops", 8'h38, 32'h0);
        verify("R3");

        // event latching and error address
        cyc(1'b0, 8'h00, '0, 1'b0, 6'b000001, 2'b00, 32'h0000_1111);
        rd_chk("R4 abnormal sync -> bit7", 8'h38, 32'h80);
        idle(); idle(); idle();
        rd_chk("R4 holds", 8'h38, 32'h80);
        wr(8'h38, 32'h7F);
        rd_chk("R4 write 0 to bit7 no effect", 8'h38, 32'h80);
        rd_chk("R7 first capture", 8'h40, 32'h0000_1111);
        cyc(1'b0, 8'h00, '0, 1'b0, 6'b100000, 2'b00, 32'h0000_2222);
        rd_chk("R4 bm turnaround -> bit2", 8'h38, 32'h84);
        rd_chk("R7 held while pending", 8'h40, 32'h0000_1111);
        cyc(1'b0, 8'h00, '0, 1'b1, 6'b000000, 2'b01, 32'h0);
        rd_chk("R4 reset bit10 and bm0 bit1", 8'h38, 32'h486);
        cyc(1'b0, 8'h00, '0, 1'b0, 6'b000000, 2'b10, 32'h0);
        rd_chk("R4 bm1 -> bit0", 8'h38, 32'h487);
        wr(8'h38, 32'h487);
        rd_chk("R4 write-1 clears", 8'h38, 32'h0);
        verify("R4");

        // collision and recapture
        cyc(1'b0, 8'h00, '0, 1'b0, 6'b000100, 2'b00, 32'h0000_3333);
        rd_chk("R7 recapture after clear", 8'h40, 32'h0000_3333);
        cyc(1'b1, 8'h38, 32'h20, 1'b0, 6'b000100, 2'b00, 32'h0000_4444);
        rd_chk("R5 event beats clear", 8'h38, 32'h20);
        rd_chk("R7 held during collision", 8'h40, 32'h0000_3333);
        wr(8'h38, 32'h20);
        verify("R5");

        // mask and summary
        wr(8'h34, 32'h0);
        cyc(1'b0, 8'h00, '0, 1'b0, 6'b000001, 2'b00, 32'h0);
        chk("R6 masked source quiet", 32'(summary_irq), 32'd0);
        wr(8'h34, 32'h80);
        chk("R6 unmasked source raises", 32'(summary_irq), 32'd1);
        verify("R6");

        // upstream
        wr(8'h54, 32'h800);
        wr(8'h58, 32'h0);
        chk("R8 up_irq active high", 32'(up_irq), 32'd1);
        wr(8'h38, 32'h80);
        wr(8'h50, 32'h800);
        idle();
        chk("R8 ack clears pin", 32'(up_irq), 32'd0);
        wr(8'h58, 32'h800);
        chk("R8 polarity inverts pin", 32'(up_irq), 32'd1);
        wr(8'h58, 32'h0);
        verify("R8");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            logic [31:0] r, wd;
            logic we, rv;
            logic [5:0] er;
            logic [1:0] bm;
            r = $urandom;
            if (r[2:0] == 3'd0) serirq_lvl = 17'($urandom) & 17'($urandom);
            we = (r[4:3] == 2'd0);
            case (r[7:5])
                3'd0: a = 8'h30;
                3'd1: a = 8'h34;
                3'd2: a = 8'h38;
                3'd3: a = 8'h38;
                3'd4: a = 8'h40;
                3'd5: a = 8'h50;
                3'd6: a = 8'h54;
                default: a = 8'h58;
            endcase
            wd = $urandom;
            if (a == 8'h30) wd[31] = r[20] | r[21];
            er = (r[11:8] == 4'd0) ? 6'($urandom) : 6'd0;
            rv = (r[16:12] == 5'd0);
            bm = (r[19:17] == 3'd0) ? 2'($urandom) : 2'd0;
            cyc(we, a, wd, rv, er, bm, $urandom);
            verify("R6 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule